// File: doc/BRIEF.md
# VME Function Window Address Decoder

This block sits behind the address-latching stage of a VME slave. Each cycle's latched address and address-modifier code are checked against a set of function windows, and the block reports which window, if any, claims the cycle. It also gives the cycle's address expressed relative to that window's base, so the local bus behind the slave always sees each window starting at address zero.

Each function window is described by three things. A compare register is supplied at run time on a port. A mask constant picks which address bits are compared, and a function whose mask is zero is removed from the design. A capability constant lists the modifier codes the function may accept. A build parameter picks how the modifier is checked. In the default mode, the modifier programmed in the compare register must equal the cycle's modifier. In the compatibility mode, any modifier enabled in the capability constant is accepted.

Only the 16-, 24- and 32-bit address spaces are recognised. Bus-lock modifier codes are never accepted.

Top module: `vme_window_decoder`

## Requirements
- R1: Modifier codes 0x08 to 0x0F select the 32-bit space, 0x38 to 0x3F select the 24-bit space, and 0x29 and 0x2D select the 16-bit space. Any other code never produces a hit.
- R2: The lock codes 0x05, 0x32 and 0x2C never produce a hit, even when a function's capability constant enables them or its compare register holds them.
- R3: A function's compare word carries the compare bits in bits 31:8 and a modifier code in bits 7:2. The address matches when every address bit selected by the mask (bits 31:8), within the space's width, equals the compare bit. For a 16-bit cycle only bits 15:8 count, and for a 24-bit cycle only bits 23:8.
- R4: With DECODE_AM=1 (default), a function also needs the modifier field of its compare word to equal the cycle's modifier.
- R5: With DECODE_AM=0, a function also needs the capability bit indexed by the cycle's modifier to be set. The modifier field of its compare word is ignored.
- R6: A function whose mask constant is zero never matches, whatever its compare word holds.
- R7: When several functions match, the output index is the lowest-numbered one.
- R8: On a hit, the offset is the address with the mask-selected bits and the bits above the space width cleared. On a miss, both the index and the offset are zero.
- R9: The outputs update on the clock edge where addr_stb is high, and they hold their values while addr_stb is low.
- R10: A clock edge with rst_n low clears the hit flag, the index and the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_stb | input | 1 | Address and modifier are latched and valid this cycle |
| addr_in | input | 32 | Latched VME address |
| am_in | input | 6 | Latched address-modifier code |
| ader_in | input | NUM_FUNC*32 | Compare words; function i sits in bits 32*i+31 down to 32*i |
| win_hit | output | 1 | A function window claims the cycle |
| win_idx | output | IDX_W | Index of the winning function |
| win_offset | output | 32 | Address relative to the winning window's base |

## Verification
Two copies run side by side, one in each modifier mode, and receive the same cycles. Each space is tried with an in-window address, and one case puts garbage in the bits above the space width, which tells width masking apart from a full 32-bit compare. Cycles whose modifier is in the capability list but differs from the programmed field separate the two modes. Lock codes and an unsupported code test rejection. Overlapping windows test priority, and a disabled function whose compare word would otherwise claim the cycle tests removal. Changing the inputs with the strobe low, and resetting after a hit, test the register behaviour.

// File: rtl/vmedec_pkg.sv
// Package: shared address-space type and modifier-code classification for
// the window decoder. Assumes 6-bit modifier codes and 32-bit addresses.
package vmedec_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_A16  = 2'd1,
        SP_A24  = 2'd2,
        SP_A32  = 2'd3
    } space_e;

    // Map a modifier code to the address space it selects (lock codes -> none)
    function automatic space_e am_space(input logic [5:0] am);
        space_e s;
        case (am)
            6'h08, 6'h09, 6'h0A, 6'h0B,
            6'h0C, 6'h0D, 6'h0E, 6'h0F: s = SP_A32;
            6'h38, 6'h39, 6'h3A, 6'h3B,
            6'h3C, 6'h3D, 6'h3E, 6'h3F: s = SP_A24;
            6'h29, 6'h2D:               s = SP_A16;
            default:                    s = SP_NONE;
        endcase
        return s;
    endfunction

    // Address bits that are meaningful in a given space
    function automatic logic [31:0] space_mask(input space_e s);
        logic [31:0] m;
        case (s)
            SP_A16:  m = 32'h0000_FFFF;
            SP_A24:  m = 32'h00FF_FFFF;
            SP_A32:  m = 32'hFFFF_FFFF;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

    // Bus-lock modifier codes, which must never be accepted
    function automatic logic am_is_lock(input logic [5:0] am);
        return (am == 6'h05) || (am == 6'h32) || (am == 6'h2C);
    endfunction

endpackage

// File: rtl/vmedec_fn_match.sv
// Module: compare logic for one enabled function window.
// Checks the address against the compare bits under the mask, restricted to the
// cycle's space width, checks the modifier in the chosen mode, and forms the
// offset from the window base. Assumes the mask constant is non-zero; disabled
// functions are not instantiated.
module vmedec_fn_match
    import vmedec_pkg::*;
#(
    parameter logic [31:0] MASK      = 32'hFF00_0000,
    parameter logic [63:0] CAPS      = 64'h0000_0000_0000_FF00,
    parameter bit          DECODE_AM = 1'b1
) (
    input  logic [31:0] addr,
    input  logic [5:0]  am,
    input  logic [31:0] ader,
    output logic        match,
    output logic [31:0] offset
);

    localparam logic [31:0] SEL_MASK = {MASK[31:8], 8'h00};

    space_e      space;
    logic [31:0] width_mask;
    logic [31:0] cmp_mask;
    logic        addr_ok;
    logic        am_ok;
    logic        ader_unused;

    assign ader_unused = ^ader[1:0];

    // Classify the cycle and build the effective compare mask
    always_comb begin
        space      = am_space(am);
        width_mask = space_mask(space);
        cmp_mask   = SEL_MASK & width_mask;
    end

    // Address and modifier acceptance for this window
    always_comb begin
        addr_ok = (((addr ^ {ader[31:8], 8'h00}) & cmp_mask) == 32'h0);
        if (DECODE_AM) begin
            am_ok = (ader[7:2] == am);
        end else begin
            am_ok = CAPS[am];
        end
        match  = (space != SP_NONE) && addr_ok && am_ok;
        offset = addr & width_mask & ~SEL_MASK;
    end

endmodule

// File: rtl/vmedec_pick.sv
// Module: fixed-priority selector over the per-function match flags.
// The lowest-numbered matching function wins and its offset is passed on.
// With no match the index and offset are zero. Purely combinational.
module vmedec_pick #(
    parameter int NUM_FUNC = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_FUNC-1:0]       match_vec,
    input  logic [NUM_FUNC-1:0][31:0] offset_vec,
    output logic                      any_hit,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [31:0]               sel_offset,
    output logic [NUM_FUNC-1:0]       grant
);

    // Walk from the top so the lowest matching index is left selected
    always_comb begin
        sel_idx    = '0;
        sel_offset = '0;
        grant      = '0;
        for (int i = NUM_FUNC - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_idx    = IDX_W'(i);
                sel_offset = offset_vec[i];
                grant      = '0;
                grant[i]   = 1'b1;
            end
        end
        any_hit = |match_vec;
    end

endmodule

// File: rtl/vme_window_decoder.sv
// Module: top of the function window decoder.
// Instantiates a comparator for each function whose mask constant is non-zero
// and ties the others off. A priority selector picks the winner, and the result
// is registered on each address strobe. Assumes addr_in and am_in are stable
// whenever addr_stb is high. Synchronous active-low reset.
module vme_window_decoder
    import vmedec_pkg::*;
#(
    parameter int                             NUM_FUNC  = 4,
    parameter logic [NUM_FUNC-1:0][31:0]      ADEM_TAB  = {32'h0000_0000, 32'h0000_FF00,
                                                           32'h00F8_0000, 32'hFF00_0000},
    parameter logic [NUM_FUNC-1:0][63:0]      AMCAP_TAB = {64'h0000_0000_0000_0000,
                                                           64'h0000_3200_0000_0000,
                                                           64'hFF04_0000_0000_0000,
                                                           64'h0000_0000_0000_FF20},
    parameter bit                             DECODE_AM = 1'b1,
    localparam int                            IDX_W     = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_stb,
    input  logic [31:0]             addr_in,
    input  logic [5:0]              am_in,
    input  logic [NUM_FUNC*32-1:0]  ader_in,
    output logic                    win_hit,
    output logic [IDX_W-1:0]        win_idx,
    output logic [31:0]             win_offset
);

    logic [NUM_FUNC-1:0]       match_vec;
    logic [NUM_FUNC-1:0][31:0] offset_vec;
    logic [NUM_FUNC-1:0]       grant;
    logic                      any_hit;
    logic [IDX_W-1:0]          sel_idx;
    logic [31:0]               sel_offset;

    // Comparator per enabled function; disabled ones have no compare register
    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
        if (ADEM_TAB[i][31:8] != 24'h0) begin : g_on
            vmedec_fn_match #(
                .MASK      (ADEM_TAB[i]),
                .CAPS      (AMCAP_TAB[i]),
                .DECODE_AM (DECODE_AM)
            ) u_match (
                .addr   (addr_in),
                .am     (am_in),
                .ader   (ader_in[i*32 +: 32]),
                .match  (match_vec[i]),
                .offset (offset_vec[i])
            );
        end else begin : g_off
            logic ader_unused;
            assign ader_unused   = ^ader_in[i*32 +: 32];
            assign match_vec[i]  = 1'b0;
            assign offset_vec[i] = 32'h0;

            // R6
            disabled_fn_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_hit |-> (win_idx != IDX_W'(i)));
        end
    end

    vmedec_pick #(
        .NUM_FUNC (NUM_FUNC),
        .IDX_W    (IDX_W)
    ) u_pick (
        .match_vec  (match_vec),
        .offset_vec (offset_vec),
        .any_hit    (any_hit),
        .sel_idx    (sel_idx),
        .sel_offset (sel_offset),
        .grant      (grant)
    );

    // Capture the decode result on each address strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hit    <= 1'b0;
            win_idx    <= '0;
            win_offset <= '0;
        end else if (addr_stb) begin
            win_hit    <= any_hit;
            win_idx    <= sel_idx;
            win_offset <= sel_offset;
        end
    end

    function automatic logic [31:0] mask_of(input logic [IDX_W-1:0] k);
        return {ADEM_TAB[k][31:8], 8'h00};
    endfunction

    // R2
    lock_am_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && am_is_lock(am_in)) |=> !win_hit);

    // R9
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> ($stable(win_hit) && $stable(win_idx) && $stable(win_offset)));

    // R8
    offset_below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ((win_offset & mask_of(win_idx)) == 32'h0));

    // R8
    miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> ((win_idx == '0) && (win_offset == 32'h0)));

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any_hit == (grant != '0)));

endmodule

// File: tb/vme_window_decoder_test.sv
`timescale 1ns/1ps
module vme_window_decoder_test;

    localparam int NF = 4;
    localparam logic [NF-1:0][31:0] B_ADEM  = {32'h0000_0000, 32'h0000_FF00,
                                               32'h00F8_0000, 32'hFF00_0000};
    localparam logic [NF-1:0][63:0] B_AMCAP = {64'h0000_0000_0000_0000,
                                               64'h0000_3200_0000_0000,
                                               64'hFF04_0000_0000_0000,
                                               64'h0000_0000_0000_FF20};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_stb = 1'b0;
    logic [31:0] addr_in = '0;
    logic [5:0]  am_in = '0;
    logic [31:0] ader_v [NF];
    logic [NF*32-1:0] ader_in;

    logic        d_hit, c_hit;
    logic [1:0]  d_idx, c_idx;
    logic [31:0] d_off, c_off;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int f = 0; f < NF; f++) ader_in[f*32 +: 32] = ader_v[f];
    end

    vme_window_decoder #(.NUM_FUNC(NF), .ADEM_TAB(B_ADEM), .AMCAP_TAB(B_AMCAP),
                         .DECODE_AM(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_in(addr_in),
        .am_in(am_in), .ader_in(ader_in),
        .win_hit(d_hit), .win_idx(d_idx), .win_offset(d_off));

    vme_window_decoder #(.NUM_FUNC(NF), .ADEM_TAB(B_ADEM), .AMCAP_TAB(B_AMCAP),
                         .DECODE_AM(1'b0)) uut_compat (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_in(addr_in),
        .am_in(am_in), .ader_in(ader_in),
        .win_hit(c_hit), .win_idx(c_idx), .win_offset(c_off));

    typedef struct {
        logic        hit;
        logic [1:0]  idx;
        logic [31:0] off;
        logic        chit;
        logic [1:0]  cidx;
        logic [31:0] coff;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;

    // Expected decode built from the requirements
    function automatic void model(input logic [31:0] a, input logic [5:0] m, input bit compat,
                                  output logic h, output logic [1:0] ix, output logic [31:0] off);
        logic [31:0] wm;
        logic [31:0] sel;
        logic        am_ok;
        case (m)
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F: wm = 32'hFFFF_FFFF;
            6'h38, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3E, 6'h3F: wm = 32'h00FF_FFFF;
            6'h29, 6'h2D: wm = 32'h0000_FFFF;
            default: wm = 32'h0;
        endcase
        h = 1'b0; ix = 2'd0; off = 32'h0;
        for (int f = NF - 1; f >= 0; f--) begin
            sel = {B_ADEM[f][31:8], 8'h00};
            am_ok = compat ? B_AMCAP[f][m] : (ader_v[f][7:2] == m);
            if (sel != 0 && wm != 0 && am_ok &&
                (((a ^ ader_v[f]) & sel & wm) == 0)) begin
                h = 1'b1; ix = 2'(f); off = a & wm & ~sel;
            end
        end
    endfunction

    task automatic compare(input exp_t e, input string where);
        n_vec++;
        if (d_hit !== e.hit || d_idx !== e.idx || d_off !== e.off) begin
            n_bad++;
            $display("FAIL %s %s default-mode: got hit=%0b idx=%0d off=%h, expected hit=%0b idx=%0d off=%h",
                     e.tag, where, d_hit, d_idx, d_off, e.hit, e.idx, e.off);
        end
        n_vec++;
        if (c_hit !== e.chit || c_idx !== e.cidx || c_off !== e.coff) begin
            n_bad++;
            $display("FAIL %s %s compat-mode: got hit=%0b idx=%0d off=%h, expected hit=%0b idx=%0d off=%h",
                     e.tag, where, c_hit, c_idx, c_off, e.chit, e.cidx, e.coff);
        end
    endtask

    // Driver: present one latched cycle and queue its expected result
    task automatic apply(input logic [31:0] a, input logic [5:0] m, input string tag);
        exp_t e;
        model(a, m, 1'b0, e.hit, e.idx, e.off);
        model(a, m, 1'b1, e.chit, e.cidx, e.coff);
        e.tag = tag;
        @(negedge clk);
        addr_in = a; am_in = m; addr_stb = 1'b1;
        sb_q.push_back(e);
        last_exp = e;
        @(negedge clk);
        addr_stb = 1'b0;
    endtask

    // Monitor: after each strobed edge, pop and compare at the falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (addr_stb && rst_n) begin
                @(negedge clk);
                if (sb_q.size() > 0) compare(sb_q.pop_front(), "scoreboard");
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        finish_run();
    end

    initial begin
        exp_t z;
        z.hit = 0; z.idx = 0; z.off = 0; z.chit = 0; z.cidx = 0; z.coff = 0;
        ader_v[0] = 32'h1200_0024;   // compare 0x12xxxxxx, modifier 0x09
        ader_v[1] = 32'h00A8_00E4;   // compare bits 23:19 = 0xA8, modifier 0x39
        ader_v[2] = 32'h0000_56A4;   // compare bits 15:8 = 0x56, modifier 0x29
        ader_v[3] = 32'h5500_0024;   // would claim 0x55xxxxxx if enabled

        repeat (3) @(posedge clk);
        @(negedge clk);
        z.tag = "R10"; compare(z, "after reset");
        rst_n = 1'b1;

        apply(32'h1234_5678, 6'h09, "R3 R4 R8 A32 window");
        // R9: inputs change with strobe low, outputs must hold
        @(negedge clk);
        addr_in = 32'h0000_56AB; am_in = 6'h29;
        repeat (2) @(negedge clk);
        compare(last_exp, "R9 hold");

        apply(32'h1234_5678, 6'h0D, "R4 R5 modifier differs from field");
        apply(32'h00AC_1234, 6'h39, "R1 R3 A24 window");
        apply(32'hFFA8_1000, 6'h3D, "R3 R5 A24 upper bits ignored");
        apply(32'h0000_56AB, 6'h29, "R1 R8 A16 window");
        apply(32'h0000_57AB, 6'h29, "R3 A16 miss");
        apply(32'h5500_0000, 6'h09, "R6 disabled function");

        ader_v[0] = 32'h1200_0014;   // field holds the A32 lock code
        apply(32'h1200_0000, 6'h05, "R2 A32 lock");
        apply(32'h00A8_0000, 6'h32, "R2 A24 lock");
        apply(32'h0000_5600, 6'h2C, "R2 A16 lock");
        ader_v[0] = 32'h1200_0040;   // field holds unsupported 0x10
        apply(32'h1200_0000, 6'h10, "R1 unsupported code");
        ader_v[0] = 32'h1200_0024;

        ader_v[1] = 32'h00A8_0024;   // second window now also answers 0x09
        apply(32'h12A8_1111, 6'h09, "R7 overlap lowest wins");
        apply(32'h13A8_1111, 6'h09, "R7 only second window");

        apply(32'h1234_5678, 6'h09, "R8 hit before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        z.tag = "R10"; compare(z, "mid-run reset");
        rst_n = 1'b1;

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule